// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block keeps the two error tallies a CAN node uses for fault confinement: one for its own transmissions and one for what it receives. Single-cycle event pulses from the protocol engine raise or lower these tallies. A transmit error, a receive error or a primary receive error each raises its tally by its own step. A clean transmit or receive lowers its tally by one. From the two values the block derives the node's confinement state: error-active, error-passive or bus-off.

Both tallies are visible on output ports on every cycle. Software can preset both of them to one shared value, but only while its initialisation flag is held. A separate recovery pulse returns the node to a clean state once the external recovery sequence has finished.

Top module: `can_fault_counters`

## Requirements
- R1: After reset both counters read 0, `err_active` is 1, and `err_passive` and `bus_off` are 0.
- R2: A `tx_err_evt` pulse raises the transmit counter by 8 on the next clock edge. A result above 255 holds the counter at 255.
- R3: A `rx_err_evt` pulse raises the receive counter by 1, or by 8 when `rx_err_primary` is 1 in the same cycle. The counter saturates at 255 and never causes bus-off.
- R4: A `tx_ok_evt` or `rx_ok_evt` pulse lowers the matching counter by 1. A counter at 0 stays at 0. When an error pulse and a success pulse reach the same counter in one cycle, the error is applied and the success is dropped.
- R5: With `sw_init` at 1, a `cnt_wr_en` pulse loads `cnt_wr_data` into both counters on the next edge. This load overrides error and success events.
- R6: With `sw_init` at 0, `cnt_wr_en` has no effect on either counter.
- R7: Exactly one of `err_active`, `err_passive` and `bus_off` is 1 at any time. `err_passive` is 1 when bus-off is not set and either counter is 128 or more.
- R8: A transmit error that would take the transmit counter beyond 255 sets `bus_off`. The flag stays set until recovery, whatever the counters do in the meantime.
- R9: A `busoff_recover` pulse clears both counters and `bus_off` on the next edge. It takes priority over writes and events in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err_evt | input | 1 | Transmit error detected (one-cycle pulse) |
| rx_err_evt | input | 1 | Receive error detected (one-cycle pulse) |
| rx_err_primary | input | 1 | Qualifies `rx_err_evt` as a primary receive error (step 8) |
| tx_ok_evt | input | 1 | Frame transmitted successfully (one-cycle pulse) |
| rx_ok_evt | input | 1 | Frame received successfully (one-cycle pulse) |
| sw_init | input | 1 | Software initialisation active; enables counter loads |
| cnt_wr_en | input | 1 | Load request for both counters |
| cnt_wr_data | input | 8 | Value loaded into both counters |
| busoff_recover | input | 1 | Recovery done; clears counters and bus-off |
| tx_err_cnt | output | 8 | Transmit error counter |
| rx_err_cnt | output | 8 | Receive error counter |
| err_active | output | 1 | Node is error-active |
| err_passive | output | 1 | Node is error-passive |
| bus_off | output | 1 | Node is bus-off |

## Verification
The assertions check the rules that hold on every cycle:
- Exactly one confinement state is reported, and the passive threshold is honoured.
- The transmit step of 8 applies below saturation, and the receive counter floors at zero.
- A write made outside initialisation leaves both counters untouched.
- Bus-off stays set until recovery, and recovery clears all state.

Some outcomes can only be shown by the bench's directed scenarios, because they need set-up sequences to reach them:
- saturation exactly at 255;
- the moment bus-off is entered;
- the primary and plain receive steps;
- the error-over-success priority;
- the shared load value reaching both counters.

// File: rtl/can_fc_pkg.sv
// Package: shared types for the fault-confinement counter block.
// Assumes: nothing beyond IEEE 1800-2017.
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_t;
endpackage

// File: rtl/can_fc_err_counter.sv
// Module: saturating up/down error counter with two selectable up-steps.
// Priority per cycle: clear, then load, then increment, then decrement.
// An optional sticky overflow flag records an increment past the maximum.
// Assumes: STEP_A and STEP_B are below 2**W.
module can_fc_err_counter #(
    parameter int W       = 8,
    parameter int STEP_A  = 1,
    parameter int STEP_B  = 8,
    parameter bit HAS_OVF = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    input  logic         inc_big,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    localparam logic [W:0]   CNT_MAX_EXT = {1'b0, {W{1'b1}}};
    localparam logic [W:0]   STEP_A_V    = (W+1)'(STEP_A);
    localparam logic [W:0]   STEP_B_V    = (W+1)'(STEP_B);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    logic [W:0]   sum;
    logic         wrap;

    // Purpose: widened sum of the count and the selected step.
    always_comb begin
        sum = {1'b0, cnt_q} + (inc_big ? STEP_B_V : STEP_A_V);
    end

    // Purpose: an increment that actually applies and passes the maximum.
    assign wrap = inc && !clear && !load && (sum > CNT_MAX_EXT);

    // Purpose: next-count selection in priority order.
    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (inc) begin
            cnt_d = wrap ? CNT_MAX_EXT[W-1:0] : sum[W-1:0];
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    // Purpose: count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    generate
        if (HAS_OVF) begin : g_ovf
            logic ovf_q;
            // Purpose: sticky overflow flag, cleared only by reset or clear.
            always_ff @(posedge clk) begin
                if (!rst_n)     ovf_q <= 1'b0;
                else if (clear) ovf_q <= 1'b0;
                else if (wrap)  ovf_q <= 1'b1;
            end
            assign ovf = ovf_q;
        end else begin : g_no_ovf
            logic unused_wrap;
            assign unused_wrap = wrap;
            assign ovf = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/can_fc_state_decode.sv
// Module: derives the fault-confinement state from the counters and bus-off flag.
// Bus-off dominates; otherwise passive when either count reaches the threshold.
// Assumes: the inputs are registered values.
module can_fc_state_decode
    import can_fc_pkg::*;
#(
    parameter int W           = 8,
    parameter int PASSIVE_LIM = 128
) (
    input  logic [W-1:0] tx_cnt,
    input  logic [W-1:0] rx_cnt,
    input  logic         boff,
    output fc_state_t    state
);
    localparam logic [W-1:0] LIM_V = W'(PASSIVE_LIM);

    // Purpose: state selection with bus-off first.
    always_comb begin
        if (boff)                                   state = FC_BUSOFF;
        else if ((tx_cnt >= LIM_V) || (rx_cnt >= LIM_V)) state = FC_PASSIVE;
        else                                        state = FC_ACTIVE;
    end
endmodule

// File: rtl/can_fault_counters.sv
// Module: top of the fault-confinement block. Holds the transmit and
// receive error counters, the bus-off flag and the state outputs.
// Assumes: event inputs are one-cycle pulses synchronous to clk.
module can_fault_counters
    import can_fc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int TX_ERR_STEP = 8,
    parameter int RX_ERR_STEP = 1,
    parameter int RX_PRI_STEP = 8,
    parameter int PASSIVE_LIM = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err_evt,
    input  logic             rx_err_evt,
    input  logic             rx_err_primary,
    input  logic             tx_ok_evt,
    input  logic             rx_ok_evt,
    input  logic             sw_init,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             busoff_recover,
    output logic [CNT_W-1:0] tx_err_cnt,
    output logic [CNT_W-1:0] rx_err_cnt,
    output logic             err_active,
    output logic             err_passive,
    output logic             bus_off
);
    logic      load_ok;
    logic      tx_ovf;
    logic      rx_ovf;
    fc_state_t state;

    // Purpose: a shared load is honoured only during software init.
    assign load_ok = sw_init && cnt_wr_en;

    can_fc_err_counter #(
        .W(CNT_W), .STEP_A(TX_ERR_STEP), .STEP_B(TX_ERR_STEP), .HAS_OVF(1'b1)
    ) u_tx_cnt (
        .clk(clk), .rst_n(rst_n), .clear(busoff_recover), .load(load_ok),
        .load_val(cnt_wr_data), .inc(tx_err_evt), .inc_big(1'b0),
        .dec(tx_ok_evt), .cnt(tx_err_cnt), .ovf(tx_ovf)
    );

    can_fc_err_counter #(
        .W(CNT_W), .STEP_A(RX_ERR_STEP), .STEP_B(RX_PRI_STEP), .HAS_OVF(1'b0)
    ) u_rx_cnt (
        .clk(clk), .rst_n(rst_n), .clear(busoff_recover), .load(load_ok),
        .load_val(cnt_wr_data), .inc(rx_err_evt), .inc_big(rx_err_primary),
        .dec(rx_ok_evt), .cnt(rx_err_cnt), .ovf(rx_ovf)
    );

    can_fc_state_decode #(
        .W(CNT_W), .PASSIVE_LIM(PASSIVE_LIM)
    ) u_decode (
        .tx_cnt(tx_err_cnt), .rx_cnt(rx_err_cnt), .boff(tx_ovf), .state(state)
    );

    logic unused_rx_ovf;
    assign unused_rx_ovf = rx_ovf;

    // Purpose: one-hot status outputs from the decoded state.
    assign err_active  = (state == FC_ACTIVE);
    assign err_passive = (state == FC_PASSIVE);
    assign bus_off     = (state == FC_BUSOFF);
endmodule

// File: rtl/can_fault_counters_chk.sv
// Module: assertion checker for can_fault_counters, attached by bind.
// Assumes: default 8-bit counters with step 8 for transmit errors.
module can_fault_counters_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_err_evt,
    input logic       rx_err_evt,
    input logic       tx_ok_evt,
    input logic       rx_ok_evt,
    input logic       sw_init,
    input logic       cnt_wr_en,
    input logic       busoff_recover,
    input logic [7:0] tx_err_cnt,
    input logic [7:0] rx_err_cnt,
    input logic       err_active,
    input logic       err_passive,
    input logic       bus_off
);
    AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({err_active, err_passive, bus_off}) == 1); // R7

    AST_PASSIVE_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_off && (tx_err_cnt >= 8'd128 || rx_err_cnt >= 8'd128)) |-> err_passive); // R7

    AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_evt && !busoff_recover && !(sw_init && cnt_wr_en) && tx_err_cnt <= 8'd247)
        |=> tx_err_cnt == $past(tx_err_cnt) + 8'd8); // R2

    AST_RX_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ok_evt && !rx_err_evt && !busoff_recover && !(sw_init && cnt_wr_en) && rx_err_cnt == 8'd0)
        |=> rx_err_cnt == 8'd0); // R4

    AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr_en && !sw_init && !busoff_recover && !tx_err_evt && !rx_err_evt && !tx_ok_evt && !rx_ok_evt)
        |=> ($stable(tx_err_cnt) && $stable(rx_err_cnt))); // R6

    AST_BUSOFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !busoff_recover) |=> bus_off); // R8

    AST_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_recover |=> (tx_err_cnt == 8'd0 && rx_err_cnt == 8'd0 && !bus_off)); // R9
endmodule

bind can_fault_counters can_fault_counters_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_err_evt(tx_err_evt), .rx_err_evt(rx_err_evt),
    .tx_ok_evt(tx_ok_evt), .rx_ok_evt(rx_ok_evt), .sw_init(sw_init),
    .cnt_wr_en(cnt_wr_en), .busoff_recover(busoff_recover),
    .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt), .err_active(err_active),
    .err_passive(err_passive), .bus_off(bus_off)
);

// File: tb/sim_can_fault_counters.sv
// Directed bench: one task per scenario; inputs change 1 time unit after
// the rising edge, results are sampled at that same point after each edge.
module sim_can_fault_counters;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_err_evt = 0, rx_err_evt = 0, rx_err_primary = 0;
    logic       tx_ok_evt = 0, rx_ok_evt = 0;
    logic       sw_init = 0, cnt_wr_en = 0, busoff_recover = 0;
    logic [7:0] cnt_wr_data = 8'd0;
    logic [7:0] tx_err_cnt, rx_err_cnt;
    logic       err_active, err_passive, bus_off;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    can_fault_counters u0 (
        .clk(clk), .rst_n(rst_n), .tx_err_evt(tx_err_evt), .rx_err_evt(rx_err_evt),
        .rx_err_primary(rx_err_primary), .tx_ok_evt(tx_ok_evt), .rx_ok_evt(rx_ok_evt),
        .sw_init(sw_init), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .busoff_recover(busoff_recover), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .err_active(err_active), .err_passive(err_passive), .bus_off(bus_off)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock edge, then all pulse inputs return low.
    task automatic tick();
        @(posedge clk); #1;
        tx_err_evt = 0; rx_err_evt = 0; rx_err_primary = 0;
        tx_ok_evt = 0; rx_ok_evt = 0; cnt_wr_en = 0; busoff_recover = 0;
    endtask

    task automatic check_state(input string req, input int a, input int p, input int b);
        check({req, " active"}, err_active, a);
        check({req, " passive"}, err_passive, p);
        check({req, " busoff"}, bus_off, b);
    endtask

    task automatic sw_load(input logic [7:0] v);
        sw_init = 1; cnt_wr_en = 1; cnt_wr_data = v; tick(); sw_init = 0;
    endtask

    task automatic recover();
        busoff_recover = 1; tick();
    endtask

    task automatic t_reset();
        check("R1 tec", tx_err_cnt, 0);
        check("R1 rec", rx_err_cnt, 0);
        check_state("R1", 1, 0, 0);
    endtask

    task automatic t_tx_steps();
        for (int i = 0; i < 3; i++) begin tx_err_evt = 1; tick(); end
        check("R2 tec after 3 errors", tx_err_cnt, 24);
        for (int i = 0; i < 5; i++) begin tx_ok_evt = 1; tick(); end
        check("R4 tec after 5 ok", tx_err_cnt, 19);
        tx_err_evt = 1; tx_ok_evt = 1; tick();
        check("R4 tx error wins over ok", tx_err_cnt, 27);
        recover();
    endtask

    task automatic t_rx_steps();
        rx_err_evt = 1; tick();
        check("R3 rec plain step", rx_err_cnt, 1);
        rx_err_evt = 1; rx_err_primary = 1; tick();
        check("R3 rec primary step", rx_err_cnt, 9);
        for (int i = 0; i < 10; i++) begin rx_ok_evt = 1; tick(); end
        check("R4 rec floor at zero", rx_err_cnt, 0);
        rx_err_evt = 1; rx_ok_evt = 1; tick();
        check("R4 rx error wins over ok", rx_err_cnt, 1);
        recover();
    endtask

    task automatic t_write();
        sw_load(8'd127);
        check("R5 tec loaded", tx_err_cnt, 127);
        check("R5 rec loaded", rx_err_cnt, 127);
        check_state("R7 below threshold", 1, 0, 0);
        sw_load(8'd128);
        check_state("R7 at threshold", 0, 1, 0);
        sw_init = 0; cnt_wr_en = 1; cnt_wr_data = 8'd16; tick();
        check("R6 tec unchanged", tx_err_cnt, 128);
        check("R6 rec unchanged", rx_err_cnt, 128);
        sw_init = 1; cnt_wr_en = 1; cnt_wr_data = 8'd3; tx_err_evt = 1; rx_ok_evt = 1; tick();
        sw_init = 0;
        check("R5 load overrides events tec", tx_err_cnt, 3);
        check("R5 load overrides events rec", rx_err_cnt, 3);
        recover();
    endtask

    task automatic t_rx_passive();
        for (int i = 0; i < 16; i++) begin rx_err_evt = 1; rx_err_primary = 1; tick(); end
        check("R3 rec 16 primary", rx_err_cnt, 128);
        check_state("R7 rx passive", 0, 1, 0);
        rx_ok_evt = 1; tick();
        check_state("R7 back to active", 1, 0, 0);
        sw_load(8'd250);
        rx_err_evt = 1; rx_err_primary = 1; tick();
        check("R3 rec saturates", rx_err_cnt, 255);
        check("R3 rec no busoff", bus_off, 0);
        recover();
    endtask

    task automatic t_busoff();
        sw_load(8'd247);
        tx_err_evt = 1; tick();
        check("R2 tec reaches 255", tx_err_cnt, 255);
        check("R8 no busoff at 255", bus_off, 0);
        tx_err_evt = 1; tick();
        check("R2 tec held at 255", tx_err_cnt, 255);
        check_state("R8 busoff entered", 0, 0, 1);
        tx_ok_evt = 1; tick();
        check("R8 tec decrements", tx_err_cnt, 254);
        sw_load(8'd0);
        check_state("R8 busoff sticky", 0, 0, 1);
        recover();
        check_state("R9 after recovery", 1, 0, 0);
        sw_load(8'd200);
        busoff_recover = 1; sw_init = 1; cnt_wr_en = 1; cnt_wr_data = 8'd99;
        tx_err_evt = 1; rx_err_evt = 1; tick(); sw_init = 0;
        check("R9 recover beats load tec", tx_err_cnt, 0);
        check("R9 recover beats load rec", rx_err_cnt, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_tx_steps();
        t_rx_steps();
        t_write();
        t_rx_passive();
        t_busoff();
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        finish_run();
    end
endmodule